// File: doc/BRIEF.md
# Radio Data Bit Buffer with Dual Readout

This block sits between a radio-data demodulator and a host controller. It stores demodulated data bits in a first-in first-out buffer (128 bits by default, about a tenth of a second of traffic) and delivers them to the host over a clock/data pair. In master readout the block generates the readout clock itself and places one bit on the data line per clock period. In slave readout the host supplies the clock and the block shows data availability on an active-low status line. Both readout modes draw from the same buffer, so the host can change mode partway through a stream without losing or repeating a bit.

Nothing is stored after a reset until the demodulator reports its first group-sync detection. From then on every incoming bit is stored, whatever later sync reports say. Two select inputs choose master readout, slave readout, standby, or a reserved test setting. In standby and test the block is frozen: it stores nothing, delivers nothing and does not drive the clock.

Top module: `rds_bit_buffer`

## Requirements
- R1: The select pair {test_sel, mode_sel} decodes as 00 master, 01 slave, 10 standby and 11 test. rck_oe is high only in master. In standby and test, rdat and status_n are high, and incoming bits, sync pulses and host clock edges have no effect.
- R2: After reset, a bit is stored only once id_det has been seen. A bit that arrives in the same cycle as the first id_det is stored.
- R3: When the buffer is full and no bit leaves in the same cycle, the incoming bit is dropped and ovf goes high. ovf stays high until reset.
- R4: In master mode, rck_out and rdat stay high from reset until the cycle after the first id_det.
- R5: In master mode, each bit is framed by HALF_CYCLES clocks with rck_out high, followed by HALF_CYCLES clocks low. rdat takes the oldest unread bit on the rising edge and holds it through the falling edge. The bit is consumed on the fall.
- R6: In slave mode, status_n is low exactly while at least one unread bit is stored. After the host's falling clock edge that consumes the last bit, status_n goes high on the third system clock edge after the first edge that samples the low level (SYNC_STAGES = 2).
- R7: In slave mode, rdat shows the oldest unread bit (high when empty). Each host clock fall consumes one bit, and the next bit appears on the same edge as in R6.
- R8: Mode changes keep bit continuity. A master cycle cut short by leaving master mode consumes nothing. Slave readout then starts at the bit after the last one delivered by a completed master fall.
- R9: Reset (rst, active high) empties the buffer, clears the sync flag and ovf, raises status_n in slave mode, and returns the master clock to its held-high state.
- R10: Host clock falls on rck_in have no effect outside slave mode.
- R11: In master mode, status_n is low once a sync detection has been seen since reset, and high before that.
- R12: Bits leave in the order they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset |
| bit_vld | input | 1 | Strobe: bit_dat carries a demodulated bit |
| bit_dat | input | 1 | Demodulated data bit |
| id_det | input | 1 | Group-sync detection pulse |
| mode_sel | input | 1 | Readout select (0 master, 1 slave when test_sel is 0) |
| test_sel | input | 1 | Standby/test select |
| rck_in | input | 1 | Readout clock from the host (pad input side) |
| rck_out | output | 1 | Readout clock generated by the block |
| rck_oe | output | 1 | Enable for the bidirectional readout clock pad |
| rdat | output | 1 | Readout data |
| status_n | output | 1 | Active low: sync seen (master) or data ready (slave) |
| ovf | output | 1 | Sticky buffer overflow flag |

## Verification
The bench builds the block with DEPTH = 8, HALF_CYCLES = 4 and SYNC_STAGES = 2. With a buffer of 8 bits, the full condition and the dropped-bit rule come up after a dozen incoming bits. With a 4-cycle half period, several master clock periods fit in a short run, and a mode switch can land in the high phase of a master cycle. The two-stage synchronizer fixes the delay from a host clock fall to the status change at three system clock edges.

// File: rtl/rdsb_pkg.sv
`timescale 1ns/1ps
package rdsb_pkg;
   typedef enum logic [1:0] {RM_MASTER, RM_SLAVE, RM_STANDBY, RM_TEST} rd_mode_e;
   typedef enum logic [1:0] {SQ_HOLD, SQ_LOW, SQ_HIGH} seq_e;

   function automatic rd_mode_e decode_mode(input logic test, input logic mode);
      case ({test, mode})
         2'b00:   return RM_MASTER;
         2'b01:   return RM_SLAVE;
         2'b10:   return RM_STANDBY;
         default: return RM_TEST;
      endcase
   endfunction
endpackage

// File: rtl/rdsb_fifo.sv
`timescale 1ns/1ps
module rdsb_fifo #(
   parameter int DEPTH = 128,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic          din,
   output logic          head,
   output logic          empty,
   output logic [CW-1:0] fill,
   output logic          drop
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rdsb_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DEPTH-1:0] mem;
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             full, pop_ok, acc;

   assign full   = (cnt == CW'(DEPTH));
   assign empty  = (cnt == '0);
   assign pop_ok = pop && !empty;
   assign acc    = push && (!full || pop_ok);
   assign drop   = push && !acc;
   assign head   = mem[rp];
   assign fill   = cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (acc)    wp <= wp + AW'(1);
         if (pop_ok) rp <= rp + AW'(1);
         cnt <= cnt + CW'(acc) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (acc) mem[wp] <= din;
   end
endmodule

// File: rtl/rdsb_sync.sv
`timescale 1ns/1ps
module rdsb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rdsb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], d};
         prev <= sh[STAGES-1];
      end
   end

   assign fall = prev && !sh[STAGES-1];
endmodule

// File: rtl/rdsb_mclk.sv
`timescale 1ns/1ps
module rdsb_mclk
   import rdsb_pkg::*;
#(
   parameter int HALF = 1800,
   localparam int CNTW = (HALF < 2) ? 1 : $clog2(HALF)
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic master,
   input  logic locked,
   input  logic avail,
   input  logic head,
   output logic rck,
   output logic rdat,
   output logic pop
);
   if (HALF < 1) begin : g_bad_half
      $error("rdsb_mclk: HALF must be at least 1");
   end

   localparam logic [CNTW-1:0] LAST = CNTW'(HALF - 1);

   seq_e            st;
   logic [CNTW-1:0] cnt;

   assign pop = master && (st == SQ_HIGH) && (cnt == LAST);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st   <= SQ_HOLD;
         cnt  <= '0;
         rck  <= 1'b1;
         rdat <= 1'b1;
      end else if (en) begin
         case (st)
            SQ_HOLD: if (locked) begin
               st  <= SQ_LOW;
               rck <= 1'b0;
               cnt <= '0;
            end
            SQ_LOW: if (!master) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               if (avail) begin
                  st   <= SQ_HIGH;
                  rck  <= 1'b1;
                  rdat <= head;
                  cnt  <= '0;
               end
            end else begin
               cnt <= cnt + CNTW'(1);
            end
            default: if (!master || cnt == LAST) begin
               st  <= SQ_LOW;
               rck <= 1'b0;
               cnt <= '0;
            end else begin
               cnt <= cnt + CNTW'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/rds_bit_buffer.sv
`timescale 1ns/1ps
module rds_bit_buffer
   import rdsb_pkg::*;
#(
   parameter int DEPTH       = 128,
   parameter int HALF_CYCLES = 1800,
   parameter int SYNC_STAGES = 2,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_vld,
   input  logic bit_dat,
   input  logic id_det,
   input  logic mode_sel,
   input  logic test_sel,
   input  logic rck_in,
   output logic rck_out,
   output logic rck_oe,
   output logic rdat,
   output logic status_n,
   output logic ovf
);
   rd_mode_e       md;
   logic           is_master, is_slave, active;
   logic           id_seen, ovf_q;
   logic           push, pop, pop_m, pop_s, host_fall;
   logic           head, empty, drop;
   logic [CW-1:0]  fill;
   logic           m_rck, m_rdat;

   assign md        = decode_mode(test_sel, mode_sel);
   assign is_master = (md == RM_MASTER);
   assign is_slave  = (md == RM_SLAVE);
   assign active    = is_master || is_slave;
   assign push      = active && bit_vld && (id_seen || id_det);
   assign pop_s     = is_slave && host_fall;
   assign pop       = pop_s || pop_m;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         id_seen <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (active && id_det) id_seen <= 1'b1;
         if (drop)             ovf_q   <= 1'b1;
      end
   end

   rdsb_fifo #(.DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst(rst), .push(push), .pop(pop), .din(bit_dat),
      .head(head), .empty(empty), .fill(fill), .drop(drop)
   );

   rdsb_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .d(rck_in), .fall(host_fall)
   );

   rdsb_mclk #(.HALF(HALF_CYCLES)) i_mclk (
      .clk(clk), .rst(rst), .en(active), .master(is_master),
      .locked(id_seen), .avail(!empty), .head(head),
      .rck(m_rck), .rdat(m_rdat), .pop(pop_m)
   );

   always_comb begin
      rck_out  = m_rck;
      rck_oe   = is_master;
      ovf      = ovf_q;
      rdat     = 1'b1;
      status_n = 1'b1;
      if (is_master) begin
         rdat     = m_rdat;
         status_n = !id_seen;
      end else if (is_slave) begin
         rdat     = empty ? 1'b1 : head;
         status_n = empty;
      end
   end
endmodule

// File: rtl/rdsb_checker.sv
`timescale 1ns/1ps
module rdsb_checker #(
   parameter int DEPTH = 128,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst,
   input logic          test_sel,
   input logic          mode_sel,
   input logic          id_det,
   input logic          rck_oe,
   input logic          rck_out,
   input logic          rdat,
   input logic          status_n,
   input logic          ovf,
   input logic          id_seen,
   input logic [CW-1:0] fill
);
   logic slave;
   assign slave = !test_sel && mode_sel;

   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);

   p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
      fill <= CW'(DEPTH));

   p_oe_master_only_r1: assert property (@(posedge clk) disable iff (rst)
      (test_sel || mode_sel) |-> !rck_oe);

   p_hold_high_r4: assert property (@(posedge clk) disable iff (rst)
      (!test_sel && !mode_sel && !id_seen) |-> (rck_out && rdat));

   p_gate_store_r2: assert property (@(posedge clk) disable iff (rst)
      (!id_seen && !id_det) |=> (fill <= $past(fill)));

   p_ready_last_r6: assert property (@(posedge clk) disable iff (rst)
      (slave && $past(slave) && $rose(status_n)) |-> ($past(fill) == CW'(1)));

   p_data_stable_high_r5: assert property (@(posedge clk) disable iff (rst)
      (rck_oe && rck_out) |=> (!rck_oe || !rck_out || $stable(rdat)));
endmodule

bind rds_bit_buffer rdsb_checker #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst), .test_sel(test_sel), .mode_sel(mode_sel),
   .id_det(id_det), .rck_oe(rck_oe), .rck_out(rck_out), .rdat(rdat),
   .status_n(status_n), .ovf(ovf), .id_seen(id_seen), .fill(fill)
);

// File: tb/test_rds_bit_buffer.sv
`timescale 1ns/1ps
module test_rds_bit_buffer;
   localparam int DEPTH = 8;
   localparam int HALF  = 4;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_vld = 1'b0, bit_dat = 1'b0, id_det = 1'b0;
   logic mode_sel = 1'b1, test_sel = 1'b0, rck_in = 1'b0;
   logic rck_out, rck_oe, rdat, status_n, ovf;

   int    n_chk = 0, n_fail = 0, cyc = 0;
   string tag = "R9";
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   rds_bit_buffer #(.DEPTH(DEPTH), .HALF_CYCLES(HALF), .SYNC_STAGES(SYNC)) i_rds_bit_buffer (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_dat(bit_dat), .id_det(id_det),
      .mode_sel(mode_sel), .test_sel(test_sel), .rck_in(rck_in),
      .rck_out(rck_out), .rck_oe(rck_oe), .rdat(rdat), .status_n(status_n), .ovf(ovf)
   );

   // behavioural reference
   bit q[$];
   bit m_id = 0, m_ovf = 0, m_rck = 1, m_rd = 1, m_prev = 0;
   int m_seq = 0, m_cnt = 0;
   bit [SYNC-1:0] m_sh = '0;

   always @(posedge clk) begin
      if (rst) begin
         q.delete(); m_id = 0; m_ovf = 0; m_rck = 1; m_rd = 1;
         m_prev = 0; m_seq = 0; m_cnt = 0; m_sh = '0;
      end else begin
         bit mas, sla, act, fall, pop, push, acc, hd, ne;
         mas  = !test_sel && !mode_sel;
         sla  = !test_sel && mode_sel;
         act  = mas || sla;
         ne   = q.size() > 0;
         hd   = ne ? q[0] : 1'b1;
         fall = m_prev && !m_sh[SYNC-1];
         pop  = (sla && fall && ne) || (mas && m_seq == 2 && m_cnt == HALF-1);
         push = act && bit_vld && (m_id || id_det);
         acc  = push && (q.size() < DEPTH || pop);
         if (push && !acc) m_ovf = 1;
         if (pop) void'(q.pop_front());
         if (acc) q.push_back(bit_dat);
         if (act) begin
            if (m_seq == 0) begin
               if (m_id) begin m_seq = 1; m_rck = 0; m_cnt = 0; end
            end else if (m_seq == 1) begin
               if (!mas) m_cnt = 0;
               else if (m_cnt == HALF-1) begin
                  if (ne) begin m_seq = 2; m_rck = 1; m_rd = hd; m_cnt = 0; end
               end else m_cnt++;
            end else begin
               if (!mas || m_cnt == HALF-1) begin m_seq = 1; m_rck = 0; m_cnt = 0; end
               else m_cnt++;
            end
            if (id_det) m_id = 1;
         end
         m_prev = m_sh[SYNC-1];
         m_sh   = {m_sh[SYNC-2:0], rck_in};
      end
   end

   task automatic chk(string nm, logic got, logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %b exp %b at cycle %0d", tag, nm, got, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (!done) begin
         bit mas, sla;
         mas = !test_sel && !mode_sel;
         sla = !test_sel && mode_sel;
         chk("rck_oe", rck_oe, mas);
         chk("rck_out", rck_out, m_rck);
         chk("rdat", rdat, mas ? m_rd : sla ? (q.size() > 0 ? q[0] : 1'b1) : 1'b1);
         chk("status_n", status_n, mas ? !m_id : sla ? (q.size() == 0) : 1'b1);
         chk("ovf", ovf, m_ovf);
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog expired, got running expected finished");
         finish_run();
      end
   end

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(int n, int seed, bit with_id);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_vld = 1'b1;
         bit_dat = ((seed >> (i % 16)) & 1) != 0;
         id_det  = with_id && (i == 0);
         @(negedge clk);
         bit_vld = 1'b0;
         id_det  = 1'b0;
      end
   endtask

   task automatic host_read(int max_bits);
      for (int i = 0; i < max_bits; i++) begin
         @(negedge clk);
         if (status_n) break;
         rck_in = 1'b1; wait_clk(5);
         rck_in = 1'b0; wait_clk(6);
      end
   endtask

   task automatic set_mode(bit t, bit m);
      @(negedge clk); test_sel = t; mode_sel = m;
   endtask

   task automatic pulse_rst();
      @(negedge clk); rst = 1'b1; wait_clk(3); rst = 1'b0;
   endtask

   initial begin
      tag = "R9"; wait_clk(4); rst = 1'b0; wait_clk(2);
      tag = "R2"; send(3, 16'h0005, 0); wait_clk(4);
      send(5, 16'h0016, 1); wait_clk(4);
      tag = "R7"; host_read(3);
      tag = "R12"; host_read(20);
      tag = "R6"; wait_clk(8);
      tag = "R3"; send(12, 16'h0B6D, 0); wait_clk(4);
      tag = "R12"; host_read(20); wait_clk(6);
      tag = "R11"; set_mode(0, 0); wait_clk(4);
      tag = "R5"; send(5, 16'h0019, 0); wait_clk(70);
      tag = "R10"; send(3, 16'h0006, 0);
      for (int i = 0; i < 4; i++) begin rck_in = 1'b1; wait_clk(3); rck_in = 1'b0; wait_clk(3); end
      wait_clk(40);
      tag = "R8"; send(6, 16'h002D, 0); wait_clk(13);
      set_mode(0, 1); host_read(20); wait_clk(6);
      send(2, 16'h0002, 0); set_mode(0, 0); wait_clk(30);
      send(4, 16'h000A, 0); wait_clk(10); set_mode(0, 1); host_read(20); wait_clk(6);
      tag = "R1"; set_mode(1, 0); send(3, 16'h0007, 1);
      rck_in = 1'b1; wait_clk(5); rck_in = 1'b0; wait_clk(8);
      set_mode(1, 1); send(2, 16'h0003, 0); wait_clk(8);
      tag = "R4"; set_mode(0, 0); pulse_rst(); send(3, 16'h0007, 0); wait_clk(20);
      send(4, 16'h0009, 1); wait_clk(60);
      tag = "R3"; set_mode(0, 1); send(12, 16'h0F0F, 0); wait_clk(4);
      tag = "R9"; pulse_rst(); wait_clk(6);
      send(2, 16'h0001, 0); wait_clk(4);
      finish_run();
   end
endmodule